// File: doc/BRIEF.md
# Large-Page NAND Command Latch

This block is the device-side front end of a NAND flash command interface. On every clock it looks at the 8-bit I/O bus. It takes a byte as a command only when chip enable (active low) is asserted and command latch enable is high. It decodes the byte, holds the latched opcode for the downstream page logic, and raises a one-cycle execute strobe for opcodes that act at once. The page logic can also ask for the held command to be executed once its address cycles are done.

The block also holds the status byte, the current page/column address, the pending output-byte count and the output byte offset. A static parameter selects large-page mode. In that mode, the read confirm and read-cache opcodes that follow a plain read are absorbed. A random-read setup opcode clears the column part of the address. The cache-exit opcode executes immediately and drops any pending output. A device reset opcode restores the status byte, keeping only the write-protect bit, and clears the output counters.

Top module: `nand_cmd_latch`

## Requirements
- R1: A bus byte is taken as a command only on a clock edge where `ce_n` is 0 and `cle` is 1. Otherwise `cmd_q` holds its value and `exec_pulse` stays 0, unless `run_req` applies (R7).
- R2: A taken byte appears on `cmd_q` in the cycle after the sampling edge. After `rst_n` the held command is 0x00 (plain read).
- R3: Taking one of the opcodes 0xD0 (erase confirm), 0x35 (no-serial read confirm), 0xE0 (random-read confirm), 0xFF (reset) or 0x34 (cache exit) raises `exec_pulse` for exactly one cycle, together with the new `cmd_q`. Any other taken opcode, for example 0x70, leaves `exec_pulse` at 0.
- R4: With `LARGE_PAGE`=1, a byte of 0x30, 0x31 or 0x3F that arrives while `cmd_q` is 0x00 is dropped. `cmd_q` stays 0x00, no execute strobe is raised, and no other state changes.
- R5: With `LARGE_PAGE`=0, and in large-page mode when the held command is not 0x00, the bytes 0x30, 0x31 and 0x3F are latched like any other opcode.
- R6: With `LARGE_PAGE`=1, taking 0x05 clears address bits [`COL_SHIFT`-1:0] and keeps the upper bits. With `LARGE_PAGE`=0, the address is unchanged.
- R7: A `run_req` pulse in a cycle with no taken command raises `exec_pulse` for one cycle for the held command. If that command is 0x00 or 0x34, `io_len` becomes 0.
- R8: Taking 0x34 sets `io_len` to 0 on the same edge that raises `exec_pulse`.
- R9: Executing 0xFF sets `status_q` to {bit 7 kept, bits 6 and 5 set, bits 4..0 cleared}, and sets `io_len` and `io_offset` to 0.
- R10: `status_q` bit 7 is the write-enabled flag (power-on value `WP_INIT`, written by `wp_upd`). Bits 6 and 5 are the two ready flags. Bits 4..1 hold the plane flags for planes 0..3 (written by `plane_upd`). Bit 0 is 0. With defaults the power-on value is 0xE0, and status updates never change `cmd_q`.
- R11: `len_load` sets `io_len` to `len_val` and `io_offset` to 0. Each `rd_pop` with `io_len` non-zero decrements `io_len` and increments `io_offset`. When `io_len` is 0, both hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| ce_n | input | 1 | Chip enable, active low |
| cle | input | 1 | Command latch enable |
| io_in | input | 8 | I/O bus byte |
| run_req | input | 1 | Execute the held command (from address sequencer) |
| addr_we | input | 1 | Load current address |
| addr_in | input | ADDR_W | Address value to load |
| len_load | input | 1 | Load pending output length |
| len_val | input | LEN_W | Length to load |
| rd_pop | input | 1 | One output byte consumed |
| plane_upd | input | 1 | Write plane flags |
| plane_flags | input | 4 | Plane flags, plane 0 in bit 0 |
| wp_upd | input | 1 | Write the write-enabled flag |
| wp_val | input | 1 | New write-enabled flag |
| cmd_q | output | 8 | Held command |
| exec_pulse | output | 1 | One-cycle execute strobe |
| status_q | output | 8 | Status byte |
| addr_q | output | ADDR_W | Current address |
| io_len | output | LEN_W | Pending output byte count |
| io_offset | output | LEN_W | Output byte offset |

## Verification
A wrong decode shows on `cmd_q` and `exec_pulse` in the first cycle after the sampling edge. Examples are an absorbed read-cache opcode that gets latched, or an immediate opcode that gives no strobe. Errors in the counters or the status register show on `io_len`, `io_offset` and `status_q` on that same edge, and they stay wrong until the next load or reset. A column clear applied in the wrong mode, or to the wrong bits, is seen right away on `addr_q`. Running a large-page and a small-page instance side by side separates the mode-dependent cases.

// File: rtl/nand_cmd_pkg.sv
// Package: opcode values and decode helpers shared by the command latch.
// Assumes 8-bit opcodes on the I/O bus.
package nand_cmd_pkg;

    localparam logic [7:0] OP_READ0        = 8'h00;
    localparam logic [7:0] OP_RAND_SETUP   = 8'h05;
    localparam logic [7:0] OP_RD_CONFIRM   = 8'h30;
    localparam logic [7:0] OP_CACHE_SEQ    = 8'h31;
    localparam logic [7:0] OP_CACHE_END    = 8'h34;
    localparam logic [7:0] OP_NOSER_CONF   = 8'h35;
    localparam logic [7:0] OP_CACHE_LAST   = 8'h3F;
    localparam logic [7:0] OP_ERASE_CONF   = 8'hD0;
    localparam logic [7:0] OP_RAND_CONF    = 8'hE0;
    localparam logic [7:0] OP_DEV_RESET    = 8'hFF;

    // Opcodes that act as soon as they are latched.
    function automatic logic acts_at_once(input logic [7:0] op);
        return (op == OP_ERASE_CONF) || (op == OP_NOSER_CONF) ||
               (op == OP_RAND_CONF)  || (op == OP_DEV_RESET)  ||
               (op == OP_CACHE_END);
    endfunction

    // Second-cycle read opcodes that a large-page device swallows after a read.
    function automatic logic is_read_second(input logic [7:0] op);
        return (op == OP_RD_CONFIRM) || (op == OP_CACHE_SEQ) ||
               (op == OP_CACHE_LAST);
    endfunction

endpackage

// File: rtl/nand_cmd_decode.sv
// Module: nand_cmd_decode
// Classifies a bus byte against the held command. Purely combinational.
// Assumes the caller qualifies the outputs with the sampling strobe.
module nand_cmd_decode
    import nand_cmd_pkg::*;
#(
    parameter bit LARGE_PAGE = 1'b1
) (
    input  logic [7:0] byte_in,
    input  logic [7:0] held_cmd,
    output logic       swallow,
    output logic       instant,
    output logic       col_clear
);

    // Immediate-execute decode is the same in both modes.
    always_comb instant = acts_at_once(byte_in);

    generate
        if (LARGE_PAGE) begin : g_large
            // Large page: swallow read-second opcodes after a read, clear column on setup.
            always_comb begin
                swallow   = (held_cmd == OP_READ0) && is_read_second(byte_in);
                col_clear = (byte_in == OP_RAND_SETUP);
            end
        end else begin : g_small
            logic [7:0] unused_held;
            // Small page: no swallowing and no column clearing.
            always_comb begin
                unused_held = held_cmd;
                swallow     = 1'b0;
                col_clear   = 1'b0;
            end
        end
    endgenerate

endmodule

// File: rtl/nand_status_reg.sv
// Module: nand_status_reg
// Holds the status byte: bit 7 write-enabled, bits 6:5 ready, bits 4:1 plane
// flags, bit 0 zero. Device reset keeps only bit 7 and sets the ready bits.
module nand_status_reg #(
    parameter bit WP_INIT = 1'b1,
    parameter int PLANES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dev_reset,
    input  logic              plane_upd,
    input  logic [PLANES-1:0] plane_flags,
    input  logic              wp_upd,
    input  logic              wp_val,
    output logic [7:0]        status_q
);

    localparam logic [1:0] READY_BOTH = 2'b11;

    logic              wp_bit;
    logic [PLANES-1:0] plane_bits;

    // Write-enabled flag: power-on value, survives device reset.
    always_ff @(posedge clk) begin
        if (!rst_n)      wp_bit <= WP_INIT;
        else if (wp_upd) wp_bit <= wp_val;
    end

    // Plane flags: cleared by either reset, loaded by the page logic.
    always_ff @(posedge clk) begin
        if (!rst_n)         plane_bits <= '0;
        else if (dev_reset) plane_bits <= '0;
        else if (plane_upd) plane_bits <= plane_flags;
    end

    // Assemble the status byte.
    always_comb status_q = {wp_bit, READY_BOTH, plane_bits, 1'b0};

    a_r9_reset_keeps_wp: assert property (@(posedge clk) disable iff (!rst_n)
        dev_reset |=> (status_q[4:0] == 5'd0) && (status_q[6:5] == 2'b11) &&
                      (status_q[7] == $past(status_q[7])));

    a_r10_plane_load: assert property (@(posedge clk) disable iff (!rst_n)
        (plane_upd && !dev_reset) |=> status_q[4:1] == $past(plane_flags));

endmodule

// File: rtl/nand_io_counter.sv
// Module: nand_io_counter
// Pending output length and byte offset. Clear beats load, load beats pop.
module nand_io_counter #(
    parameter int LEN_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_all,
    input  logic             clr_len,
    input  logic             len_load,
    input  logic [LEN_W-1:0] len_val,
    input  logic             rd_pop,
    output logic [LEN_W-1:0] io_len,
    output logic [LEN_W-1:0] io_offset
);

    localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

    logic can_pop;
    always_comb can_pop = rd_pop && (io_len != '0);

    // Length counter.
    always_ff @(posedge clk) begin
        if (!rst_n)                  io_len <= '0;
        else if (clr_all || clr_len) io_len <= '0;
        else if (len_load)           io_len <= len_val;
        else if (can_pop)            io_len <= io_len - ONE;
    end

    // Offset counter.
    always_ff @(posedge clk) begin
        if (!rst_n)                 io_offset <= '0;
        else if (clr_all)           io_offset <= '0;
        else if (clr_len)           io_offset <= io_offset;
        else if (len_load)          io_offset <= '0;
        else if (can_pop)           io_offset <= io_offset + ONE;
    end

    a_r11_pop_step: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_pop && !len_load && !clr_all && !clr_len && io_len != '0)
        |=> (io_len == $past(io_len) - ONE) && (io_offset == $past(io_offset) + ONE));

    a_r11_empty_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_pop && !len_load && !clr_all && !clr_len && io_len == '0)
        |=> (io_len == '0) && $stable(io_offset));

    a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr_all |=> (io_len == '0) && (io_offset == '0));

endmodule

// File: rtl/nand_cmd_latch.sv
// Module: nand_cmd_latch (top)
// Device-side NAND command latch: samples commands, raises the execute strobe,
// owns the address, output counters and status byte. Assumes one bus byte per
// clock and that run_req comes from an external address sequencer.
module nand_cmd_latch
    import nand_cmd_pkg::*;
#(
    parameter bit LARGE_PAGE = 1'b1,
    parameter int ADDR_W     = 32,
    parameter int COL_SHIFT  = 12,
    parameter int LEN_W      = 12,
    parameter bit WP_INIT    = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              cle,
    input  logic [7:0]        io_in,
    input  logic              run_req,
    input  logic              addr_we,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              len_load,
    input  logic [LEN_W-1:0]  len_val,
    input  logic              rd_pop,
    input  logic              plane_upd,
    input  logic [3:0]        plane_flags,
    input  logic              wp_upd,
    input  logic              wp_val,
    output logic [7:0]        cmd_q,
    output logic              exec_pulse,
    output logic [7:0]        status_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [LEN_W-1:0]  io_len,
    output logic [LEN_W-1:0]  io_offset
);

    localparam logic [ADDR_W-1:0] KEEP_MASK = {ADDR_W{1'b1}} << COL_SHIFT;

    logic       strobe, swallow, instant, col_clear;
    logic       take, exec_now, clr_len, dev_reset;
    logic [7:0] exec_code;

    // Bus sampling qualifier.
    always_comb strobe = !ce_n && cle;

    nand_cmd_decode #(.LARGE_PAGE(LARGE_PAGE)) u_decode (
        .byte_in  (io_in),
        .held_cmd (cmd_q),
        .swallow  (swallow),
        .instant  (instant),
        .col_clear(col_clear)
    );

    // Execute selection: a taken byte beats a run request.
    always_comb begin
        take      = strobe && !swallow;
        exec_now  = take ? instant : (!strobe && run_req);
        exec_code = take ? io_in : cmd_q;
        clr_len   = exec_now && ((exec_code == OP_READ0) || (exec_code == OP_CACHE_END));
        dev_reset = exec_now && (exec_code == OP_DEV_RESET);
    end

    // Held command register.
    always_ff @(posedge clk) begin
        if (!rst_n)    cmd_q <= OP_READ0;
        else if (take) cmd_q <= io_in;
    end

    // One-cycle execute strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) exec_pulse <= 1'b0;
        else        exec_pulse <= exec_now;
    end

    // Address register: column clear beats a load on the same edge.
    always_ff @(posedge clk) begin
        if (!rst_n)                 addr_q <= '0;
        else if (take && col_clear) addr_q <= addr_q & KEEP_MASK;
        else if (addr_we)           addr_q <= addr_in;
    end

    nand_io_counter #(.LEN_W(LEN_W)) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_all  (dev_reset),
        .clr_len  (clr_len),
        .len_load (len_load),
        .len_val  (len_val),
        .rd_pop   (rd_pop),
        .io_len   (io_len),
        .io_offset(io_offset)
    );

    nand_status_reg #(.WP_INIT(WP_INIT), .PLANES(4)) u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .dev_reset  (dev_reset),
        .plane_upd  (plane_upd),
        .plane_flags(plane_flags),
        .wp_upd     (wp_upd),
        .wp_val     (wp_val),
        .status_q   (status_q)
    );

    a_r1_idle_bus: assert property (@(posedge clk) disable iff (!rst_n)
        (!(!ce_n && cle) && !run_req) |=> $stable(cmd_q) && !exec_pulse);

    a_r3_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
        exec_pulse |-> $past((!ce_n && cle) || run_req));

    a_r8_exit_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && cle && io_in == OP_CACHE_END) |=> exec_pulse && (io_len == '0));

    generate
        if (LARGE_PAGE) begin : g_lp_checks
            a_r4_swallow: assert property (@(posedge clk) disable iff (!rst_n)
                (!ce_n && cle && cmd_q == OP_READ0 &&
                 (io_in == OP_RD_CONFIRM || io_in == OP_CACHE_SEQ || io_in == OP_CACHE_LAST))
                |=> $stable(cmd_q) && !exec_pulse);

            a_r6_col_zero: assert property (@(posedge clk) disable iff (!rst_n)
                (!ce_n && cle && io_in == OP_RAND_SETUP)
                |=> (addr_q[COL_SHIFT-1:0] == '0) &&
                    (addr_q[ADDR_W-1:COL_SHIFT] == $past(addr_q[ADDR_W-1:COL_SHIFT])));
        end
    endgenerate

endmodule

// File: tb/nand_cmd_latch_tb.sv
module nand_cmd_latch_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n = 1'b1, cle = 1'b0;
    logic [7:0]  io_in = 8'h00;
    logic        run_req = 1'b0, addr_we = 1'b0, len_load = 1'b0, rd_pop = 1'b0;
    logic [31:0] addr_in = '0;
    logic [11:0] len_val = '0;
    logic        plane_upd = 1'b0, wp_upd = 1'b0, wp_val = 1'b0;
    logic [3:0]  plane_flags = '0;

    logic [7:0]  cmd_l, cmd_s, st_l, st_s;
    logic        ex_l, ex_s;
    logic [31:0] ad_l, ad_s;
    logic [11:0] len_l, len_s, off_l, off_s;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    nand_cmd_latch #(.LARGE_PAGE(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cle(cle), .io_in(io_in),
        .run_req(run_req), .addr_we(addr_we), .addr_in(addr_in),
        .len_load(len_load), .len_val(len_val), .rd_pop(rd_pop),
        .plane_upd(plane_upd), .plane_flags(plane_flags),
        .wp_upd(wp_upd), .wp_val(wp_val),
        .cmd_q(cmd_l), .exec_pulse(ex_l), .status_q(st_l), .addr_q(ad_l),
        .io_len(len_l), .io_offset(off_l));

    nand_cmd_latch #(.LARGE_PAGE(1'b0)) u_dut_sp (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cle(cle), .io_in(io_in),
        .run_req(run_req), .addr_we(addr_we), .addr_in(addr_in),
        .len_load(len_load), .len_val(len_val), .rd_pop(rd_pop),
        .plane_upd(plane_upd), .plane_flags(plane_flags),
        .wp_upd(wp_upd), .wp_val(wp_val),
        .cmd_q(cmd_s), .exec_pulse(ex_s), .status_q(st_s), .addr_q(ad_s),
        .io_len(len_s), .io_offset(off_s));

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    // Present one byte on the bus with command latch enable, then release.
    task automatic send(input logic [7:0] b);
        @(negedge clk); ce_n = 1'b0; cle = 1'b1; io_in = b;
        @(negedge clk); ce_n = 1'b1; cle = 1'b0;
    endtask

    task automatic load_len(input logic [11:0] n);
        @(negedge clk); len_load = 1'b1; len_val = n;
        @(negedge clk); len_load = 1'b0;
    endtask

    task automatic pop;
        @(negedge clk); rd_pop = 1'b1;
        @(negedge clk); rd_pop = 1'b0;
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R2 reset cmd", cmd_l, 8'h00);
        chk("R10 reset status", st_l, 8'hE0);
        chk("R11 reset len", len_l, 0);
        chk("R11 reset offset", off_l, 0);
        chk("R3 reset no pulse", ex_l, 0);
    endtask

    task automatic t_sampling;
        @(negedge clk); ce_n = 1'b1; cle = 1'b1; io_in = 8'h70;
        @(negedge clk);
        chk("R1 ce high ignored", cmd_l, 8'h00);
        ce_n = 1'b0; cle = 1'b0;
        @(negedge clk);
        chk("R1 cle low ignored", cmd_l, 8'h00);
        chk("R1 no pulse", ex_l, 0);
        ce_n = 1'b1;
        send(8'h70);
        chk("R2 latched 70", cmd_l, 8'h70);
        chk("R3 no pulse for 70", ex_l, 0);
    endtask

    task automatic t_immediate;
        logic [7:0] ops [4] = '{8'hD0, 8'h35, 8'hE0, 8'h34};
        for (int i = 0; i < 4; i++) begin
            send(ops[i]);
            chk("R3 immediate cmd", cmd_l, ops[i]);
            chk("R3 immediate pulse", ex_l, 1);
            chk("R3 immediate pulse sp", ex_s, 1);
            @(negedge clk);
            chk("R3 pulse one cycle", ex_l, 0);
        end
    endtask

    task automatic t_swallow;
        logic [7:0] ops [3] = '{8'h30, 8'h31, 8'h3F};
        for (int i = 0; i < 3; i++) begin
            send(8'h00);
            send(ops[i]);
            chk("R4 swallowed keeps read", cmd_l, 8'h00);
            chk("R4 swallowed no pulse", ex_l, 0);
            chk("R5 small page latches", cmd_s, ops[i]);
        end
        send(8'h70);
        send(8'h30);
        chk("R5 large page after non-read", cmd_l, 8'h30);
    endtask

    task automatic t_column;
        @(negedge clk); addr_we = 1'b1; addr_in = 32'hABCD_1234;
        @(negedge clk); addr_we = 1'b0;
        send(8'h05);
        chk("R6 column cleared", ad_l, 32'hABCD_1000);
        chk("R6 small page keeps address", ad_s, 32'hABCD_1234);
        chk("R6 setup latched", cmd_l, 8'h05);
    endtask

    task automatic t_length;
        load_len(12'd5);
        chk("R11 load len", len_l, 5);
        pop(); pop();
        chk("R11 len after pops", len_l, 3);
        chk("R11 offset after pops", off_l, 2);
        pop(); pop(); pop(); pop();
        chk("R11 len holds at zero", len_l, 0);
        chk("R11 offset holds at zero", off_l, 5);
    endtask

    task automatic t_run;
        load_len(12'd7);
        send(8'h00);
        chk("R7 read not immediate", ex_l, 0);
        chk("R7 len kept before run", len_l, 7);
        @(negedge clk); run_req = 1'b1;
        @(negedge clk); run_req = 1'b0;
        chk("R7 run pulse", ex_l, 1);
        chk("R7 run clears len", len_l, 0);
        load_len(12'd6);
        send(8'h70);
        @(negedge clk); run_req = 1'b1;
        @(negedge clk); run_req = 1'b0;
        chk("R7 run pulse other", ex_l, 1);
        chk("R7 other keeps len", len_l, 6);
    endtask

    task automatic t_exit;
        load_len(12'd9);
        send(8'h34);
        chk("R8 exit pulse", ex_l, 1);
        chk("R8 exit clears len", len_l, 0);
    endtask

    task automatic t_status;
        send(8'h70);
        @(negedge clk); plane_upd = 1'b1; plane_flags = 4'b1010;
        @(negedge clk); plane_upd = 1'b0;
        chk("R10 plane flags", st_l, 8'hF4);
        @(negedge clk); wp_upd = 1'b1; wp_val = 1'b0;
        @(negedge clk); wp_upd = 1'b0;
        chk("R10 wp cleared", st_l, 8'h74);
        chk("R10 cmd undisturbed", cmd_l, 8'h70);
        load_len(12'd4);
        pop();
        send(8'hFF);
        chk("R9 reset pulse", ex_l, 1);
        chk("R9 status after reset", st_l, 8'h60);
        chk("R9 len after reset", len_l, 0);
        chk("R9 offset after reset", off_l, 0);
        @(negedge clk); wp_upd = 1'b1; wp_val = 1'b1; plane_upd = 1'b1; plane_flags = 4'b0111;
        @(negedge clk); wp_upd = 1'b0; plane_upd = 1'b0;
        send(8'hFF);
        chk("R9 reset keeps wp set", st_l, 8'hE0);
    endtask

    initial begin
        #4_000_000;
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_sampling();
        t_immediate();
        t_swallow();
        t_column();
        t_length();
        t_run();
        t_exit();
        t_status();
        repeat (2) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule